// File: doc/BRIEF.md
# Saturating Accumulator with Convergent Rounding

This block is a 40-bit signed accumulator datapath. The value is a 1.31 fraction carried with eight extra guard bits above the sign, so the most significant bit (bit 39) is the true sign of the whole register. On every enabled cycle a 40-bit signed addend is added to the register. The result is then passed through one of three overflow policies: free wrap, clamping to the 1.31 range, or clamping to the full 40-bit range.

A combinational store path reduces the register to a 16-bit 1.15 word. It uses either round-half-up or round-half-to-even rounding, and it limits the result to the 16-bit signed range. Three status outputs go with the register. One shows that the value has spilled into the guard bits. One is a sticky flag that records any carry out of the full 40-bit range until it is cleared. One reports whether the last write was clamped. The block is meant to sit behind a multiplier in a multiply-accumulate pipeline.

Top module: `acc_sat_unit`

## Requirements
- R1: After reset, `acc_q` is zero, `cat_ovf` and `sat_flag` are low, `ovf_guard` is low and `store_q` is zero.
- R2: On a clock edge with `acc_en` high, `acc_q` takes the sum of its old value and `addend`. Both are read as two's complement 40-bit numbers. With `acc_en` low, `acc_q` and `sat_flag` hold.
- R3: With `sat_mode` = 2'b00, the sum wraps modulo 2^40, so the sign can flip. `sat_flag` is low after every such write.
- R4: With `sat_mode` = 2'b01, a sum above 2^31-1 is written as 0x00_7FFF_FFFF and a sum below -2^31 is written as 0xFF_8000_0000. `sat_flag` is high after a clamped write and low after a write that was not clamped.
- R5: With `sat_mode` = 2'b10 or 2'b11, a sum beyond the 40-bit range is written as 0x7F_FFFF_FFFF when it overflowed upward and 0x80_0000_0000 when it overflowed downward. `sat_flag` reports the clamp as in R4.
- R6: `ovf_guard` is high exactly when `acc_q` lies outside [-2^31, 2^31-1], which means bits 39 down to 31 are not all equal. It follows `acc_q` in the same cycle.
- R7: `cat_ovf` is set by any enabled write whose exact sum is outside the 40-bit range, in every mode. It stays set until a cycle with `cat_clr` high. If a setting write and `cat_clr` fall in the same cycle, the flag ends set.
- R8: With `round_sel` = 0, the rounding is conventional: `store_q` is bits 31:16 of `acc_q` + 0x8000.
- R9: With `round_sel` = 1, the rounding is convergent. The part of `acc_q` above bit 15 is rounded up when bits 15:0 exceed 0x8000 and kept when they are below 0x8000. On an exact 0x8000 it is rounded up only when bit 16 is 1.
- R10: A rounded value above 0x7FFF gives `store_q` = 0x7FFF. A rounded value below -0x8000 gives `store_q` = 0x8000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Write the policed sum into the register |
| addend | input | 40 | Signed addend |
| sat_mode | input | 2 | 00 wrap, 01 clamp to 1.31, 1x clamp to 40 bits |
| round_sel | input | 1 | 0 conventional, 1 convergent rounding |
| cat_clr | input | 1 | Clear the sticky 40-bit overflow flag |
| acc_q | output | 40 | Accumulator register |
| store_q | output | 16 | Rounded and clipped 1.15 word |
| ovf_guard | output | 1 | Value extends into the guard bits |
| cat_ovf | output | 1 | Sticky overflow out of bit 39 |
| sat_flag | output | 1 | Last write was clamped |

## Verification
The clear request for the sticky overflow flag and a write that overflows bit 39 can arrive in the same cycle. The bench first brings the register close to the 40-bit limit. It then issues `cat_clr` together with an addend that overflows and expects the flag to read set afterwards. Each half is also checked on its own: a clear alone must drop the flag, and a write without overflow must leave it set. The store path's rounding and clipping can also act on one value together. A value at 0x00_7FFF_8000 rounds up past 0x7FFF and must be clipped under both rounding choices.

// File: rtl/acc_sat_pkg.sv
package acc_sat_pkg;
  typedef enum logic [1:0] {
    SAT_WRAP = 2'b00,
    SAT_FRAC = 2'b01,
    SAT_FULL = 2'b10,
    SAT_FULL_ALT = 2'b11
  } sat_mode_e;
endpackage

// File: rtl/acc_sum_sat.sv
module acc_sum_sat #(
  parameter int ACC_W  = 40,
  parameter int FRAC_W = 32
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic [ACC_W-1:0] addend_i,
  input  logic [1:0]       mode_i,
  output logic [ACC_W-1:0] next_o,
  output logic             ovf_top_o,
  output logic             clamp_o
);
  import acc_sat_pkg::*;

  localparam int EXT_W = ACC_W + 1;
  localparam int TOP_W = EXT_W - (FRAC_W - 1);
  localparam logic [ACC_W-1:0] FULL_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] FULL_MIN = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic [ACC_W-1:0] FRAC_MAX = {{(ACC_W-FRAC_W+1){1'b0}}, {(FRAC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] FRAC_MIN = {{(ACC_W-FRAC_W+1){1'b1}}, {(FRAC_W-1){1'b0}}};

  function automatic logic uniform(input logic [TOP_W-1:0] v);
    return (v == '0) || (v == '1);
  endfunction

  logic [EXT_W-1:0] sum_ext;
  logic             true_neg;
  logic             frac_out;
  sat_mode_e        mode;

  assign mode      = sat_mode_e'(mode_i);
  assign sum_ext   = {acc_i[ACC_W-1], acc_i} + {addend_i[ACC_W-1], addend_i};
  assign true_neg  = sum_ext[EXT_W-1];
  assign ovf_top_o = sum_ext[EXT_W-1] ^ sum_ext[EXT_W-2];
  assign frac_out  = !uniform(sum_ext[EXT_W-1:FRAC_W-1]);

  always_comb begin
    next_o  = sum_ext[ACC_W-1:0];
    clamp_o = 1'b0;
    unique case (mode)
      SAT_WRAP: ;
      SAT_FRAC: if (frac_out) begin
        next_o  = true_neg ? FRAC_MIN : FRAC_MAX;
        clamp_o = 1'b1;
      end
      SAT_FULL, SAT_FULL_ALT: if (ovf_top_o) begin
        next_o  = true_neg ? FULL_MIN : FULL_MAX;
        clamp_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_round_clip.sv
module acc_round_clip #(
  parameter int ACC_W   = 40,
  parameter int FRAC_W  = 32,
  parameter int STORE_W = 16
) (
  input  logic [ACC_W-1:0]   acc_i,
  input  logic               conv_i,
  output logic [STORE_W-1:0] word_o
);
  localparam int LOW_W = FRAC_W - STORE_W;
  localparam int HI_W  = ACC_W - LOW_W;
  localparam int CHK_W = HI_W + 1 - (STORE_W - 1);
  localparam logic [LOW_W-1:0] HALF = {1'b1, {(LOW_W-1){1'b0}}};

  function automatic logic uniform(input logic [CHK_W-1:0] v);
    return (v == '0) || (v == '1);
  endfunction

  function automatic logic round_up(input logic [LOW_W-1:0] lo, input logic odd,
                                    input logic conv);
    if (!conv) return lo >= HALF;
    return (lo > HALF) || ((lo == HALF) && odd);
  endfunction

  logic [HI_W-1:0]  hi;
  logic [LOW_W-1:0] lo;
  logic [HI_W:0]    rnd;
  logic             inc;

  assign hi  = acc_i[ACC_W-1:LOW_W];
  assign lo  = acc_i[LOW_W-1:0];
  assign inc = round_up(lo, hi[0], conv_i);
  assign rnd = {hi[HI_W-1], hi} + {{HI_W{1'b0}}, inc};

  always_comb begin
    if (uniform(rnd[HI_W:STORE_W-1])) word_o = rnd[STORE_W-1:0];
    else word_o = rnd[HI_W] ? {1'b1, {(STORE_W-1){1'b0}}} : {1'b0, {(STORE_W-1){1'b1}}};
  end
endmodule

// File: rtl/acc_sat_unit.sv
module acc_sat_unit #(
  parameter int ACC_W   = 40,
  parameter int FRAC_W  = 32,
  parameter int STORE_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_en,
  input  logic [ACC_W-1:0]   addend,
  input  logic [1:0]         sat_mode,
  input  logic               round_sel,
  input  logic               cat_clr,
  output logic [ACC_W-1:0]   acc_q,
  output logic [STORE_W-1:0] store_q,
  output logic               ovf_guard,
  output logic               cat_ovf,
  output logic               sat_flag
);
  localparam int GUARD_TOP = ACC_W - (FRAC_W - 1);
  localparam logic [ACC_W-1:0] FULL_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] FULL_MIN = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic [STORE_W-1:0] W_MAX = {1'b0, {(STORE_W-1){1'b1}}};
  localparam logic [STORE_W-1:0] W_MIN = {1'b1, {(STORE_W-1){1'b0}}};

  logic [ACC_W-1:0] next_val;
  logic             ovf_top;
  logic             clamp_ev;
  logic [GUARD_TOP-1:0] guard_bits;

  acc_sum_sat #(.ACC_W(ACC_W), .FRAC_W(FRAC_W)) u_sum (
    .acc_i(acc_q), .addend_i(addend), .mode_i(sat_mode),
    .next_o(next_val), .ovf_top_o(ovf_top), .clamp_o(clamp_ev)
  );

  acc_round_clip #(.ACC_W(ACC_W), .FRAC_W(FRAC_W), .STORE_W(STORE_W)) u_rnd (
    .acc_i(acc_q), .conv_i(round_sel), .word_o(store_q)
  );

  assign guard_bits = acc_q[ACC_W-1:FRAC_W-1];
  assign ovf_guard  = !((guard_bits == '0) || (guard_bits == '1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q    <= '0;
      sat_flag <= 1'b0;
      cat_ovf  <= 1'b0;
    end else begin
      if (acc_en) begin
        acc_q    <= next_val;
        sat_flag <= clamp_ev;
      end
      if (acc_en && ovf_top) cat_ovf <= 1'b1;
      else if (cat_clr)      cat_ovf <= 1'b0;
    end
  end

  // R2: a disabled cycle leaves the register untouched
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |=> $stable(acc_q));
  // R3: wrap mode never reports a clamp
  a_r3_no_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && sat_mode == 2'b00) |=> !sat_flag);
  // R4: a 1.31 clamped write never leaves the value in the guard bits
  a_r4_in_frac: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && sat_mode == 2'b01) |=> !ovf_guard);
  // R5: full-range overflow lands on an extreme value
  a_r5_extreme: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && sat_mode[1] && ovf_top) |=>
      (sat_flag && (acc_q == FULL_MAX || acc_q == FULL_MIN)));
  // R7: the sticky flag is set by a top overflow and survives until cleared
  a_r7_set: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && ovf_top) |=> cat_ovf);
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cat_ovf && !cat_clr) |=> cat_ovf);
  // R10: a value outside 1.31 always stores as the limit word
  a_r10_clip: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_guard |-> (store_q == (acc_q[ACC_W-1] ? W_MIN : W_MAX)));
endmodule

// File: tb/sim_acc_sat_unit.sv
module sim_acc_sat_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_en;
  logic [39:0] addend;
  logic [1:0]  sat_mode;
  logic        round_sel;
  logic        cat_clr;
  logic [39:0] acc_q;
  logic [15:0] store_q;
  logic        ovf_guard, cat_ovf, sat_flag;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  longint exp_acc;
  bit     exp_cat, exp_sat;

  always #5 clk = ~clk;

  acc_sat_unit u0 (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .addend(addend),
    .sat_mode(sat_mode), .round_sel(round_sel), .cat_clr(cat_clr),
    .acc_q(acc_q), .store_q(store_q), .ovf_guard(ovf_guard),
    .cat_ovf(cat_ovf), .sat_flag(sat_flag)
  );

  function automatic longint sx40(input logic [39:0] v);
    return longint'({{24{v[39]}}, v});
  endfunction

  function automatic longint exp_store(input longint v, input bit conv);
    longint q, rem;
    if (!conv) q = (v + 64'sd32768) >>> 16;
    else begin
      q = v >>> 16;
      rem = v & 64'hFFFF;
      if (rem > 64'h8000) q = q + 1;
      else if (rem == 64'h8000 && q[0]) q = q + 1;
    end
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    return q & 64'hFFFF;
  endfunction

  task automatic chk(input string req, input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic check_all(input string req);
    longint lim31 = (64'sd1 <<< 31);
    chk({req, " acc"}, sx40(acc_q), exp_acc);
    chk({req, " sat_flag"}, longint'(sat_flag), longint'(exp_sat));
    chk({req, " cat_ovf R7"}, longint'(cat_ovf), longint'(exp_cat));
    chk({req, " ovf_guard R6"}, longint'(ovf_guard),
        longint'(exp_acc >= lim31 || exp_acc < -lim31));
    chk({req, " store"}, longint'(store_q), exp_store(exp_acc, round_sel));
  endtask

  task automatic step(input bit en, input logic [39:0] a, input logic [1:0] m,
                      input bit clr, input string req);
    longint s, fmax, fmin, cmax, cmin;
    bit top;
    fmax = (64'sd1 <<< 39) - 1;  fmin = -(64'sd1 <<< 39);
    cmax = (64'sd1 <<< 31) - 1;  cmin = -(64'sd1 <<< 31);
    @(negedge clk);
    acc_en = en; addend = a; sat_mode = m; cat_clr = clr;
    @(negedge clk);
    acc_en = 0; cat_clr = 0;
    s = exp_acc + sx40(a);
    top = (s > fmax) || (s < fmin);
    if (en) begin
      exp_sat = 0;
      if (m == 2'b00) exp_acc = sx40(s[39:0]);
      else if (m == 2'b01) begin
        if (s > cmax) begin exp_acc = cmax; exp_sat = 1; end
        else if (s < cmin) begin exp_acc = cmin; exp_sat = 1; end
        else exp_acc = s;
      end else begin
        if (s > fmax) begin exp_acc = fmax; exp_sat = 1; end
        else if (s < fmin) begin exp_acc = fmin; exp_sat = 1; end
        else exp_acc = s;
      end
    end
    if (en && top) exp_cat = 1;
    else if (clr) exp_cat = 0;
    #1;
    check_all(req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; acc_en = 0; addend = '0; sat_mode = 2'b00; cat_clr = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
    exp_acc = 0; exp_cat = 0; exp_sat = 0;
  endtask

  task automatic load_val(input logic [39:0] v);
    do_reset();
    step(1, v, 2'b00, 0, "load");
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk("R1 acc", longint'(acc_q), 0);
    chk("R1 store", longint'(store_q), 0);
    chk("R1 flags", longint'({cat_ovf, sat_flag, ovf_guard}), 0);
  endtask

  task automatic t_accumulate();
    do_reset();
    step(1, 40'h00_1234_5678, 2'b01, 0, "R2 first add");
    step(1, 40'h00_0000_1000, 2'b01, 0, "R2 second add");
    step(1, 40'hFF_FFFF_F000, 2'b10, 0, "R2 negative add");
    step(0, 40'h00_5555_0000, 2'b00, 0, "R2 hold when disabled");
  endtask

  task automatic t_wrap();
    do_reset();
    step(1, 40'h00_7FFF_FFFF, 2'b00, 0, "R3 near frac top");
    step(1, 40'h00_0000_0001, 2'b00, 0, "R3 R6 R10 into guard");
    load_val(40'h7F_FFFF_FFFF);
    step(1, 40'h00_0000_0002, 2'b00, 0, "R3 wrap sign flip");
  endtask

  task automatic t_sat31();
    do_reset();
    step(1, 40'h00_7FFF_0000, 2'b01, 0, "R4 below limit");
    step(1, 40'h00_0002_0000, 2'b01, 0, "R4 clamp positive");
    step(1, 40'hFF_0000_0000, 2'b01, 0, "R4 clamp negative");
    step(1, 40'h00_0000_0001, 2'b01, 0, "R4 no clamp clears sat_flag");
  endtask

  task automatic t_sat39();
    load_val(40'h7F_FFFF_FFFF);
    step(1, 40'h00_0000_0001, 2'b10, 0, "R5 clamp positive");
    load_val(40'h80_0000_0000);
    step(1, 40'hFF_FFFF_FFFF, 2'b11, 0, "R5 clamp negative alt code");
  endtask

  task automatic t_sticky();
    load_val(40'h7F_FFFF_FFFF);
    step(1, 40'h00_0000_0002, 2'b00, 0, "R7 set by wrap");
    step(1, 40'h00_0000_0001, 2'b00, 0, "R7 stays set");
    step(0, 40'h00_0000_0000, 2'b00, 1, "R7 clear alone");
    step(1, 40'h80_0000_0000, 2'b00, 1, "R7 set beats clear");
  endtask

  task automatic t_round();
    logic [39:0] vals [8];
    vals = '{40'h00_1234_8000, 40'h00_1235_8000, 40'h00_1234_8001, 40'h00_1234_7FFF,
             40'hFF_FFFF_8000, 40'hFF_FFFE_8000, 40'h00_7FFF_8000, 40'hFF_0000_0000};
    for (int i = 0; i < 8; i++) begin
      load_val(vals[i]);
      for (int c = 0; c < 2; c++) begin
        @(negedge clk);
        round_sel = c[0];
        #1;
        chk(c == 0 ? "R8 R10 conventional" : "R9 R10 convergent",
            longint'(store_q), exp_store(exp_acc, c[0]));
      end
      round_sel = 0;
    end
  endtask

  initial begin
    round_sel = 0;
    t_reset();
    t_accumulate();
    t_wrap();
    t_sat31();
    t_sat39();
    t_sticky();
    t_round();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule